// File: doc/BRIEF.md
# Cache Refill Burst Master

This block connects a data cache's line-refill logic to a 32-bit Wishbone master port. When the cache asks for a read that is cacheable, it runs a four-word incrementing burst. The burst starts at the requested word and wraps inside the line. An uncached read, a read made while the cache is switched off, and every write each go out as one Wishbone access instead.

The requester hands over one request with a valid/ready handshake. The block then owns the bus until the last beat completes. Each acknowledged beat is returned to the requester one cycle later as a response strobe. The strobe carries the data word, the word's index in the line, a fill flag, a last flag and an error flag.

Two decisions are taken from the request in the accept cycle and then held until the access ends: whether the region is cache-inhibited, and which byte selects to drive. As a result, a glitch on the address or byte-select inputs during a burst cannot disturb the bus transfer.

Top module: `crb_master`

## Requirements
- R1: During and after reset, until a request is accepted: `wb_cyc_o`, `wb_stb_o` and `rsp_valid` are low, and `rq_ready` is high.
- R2: A read request is a refill when `cache_en` is high, `cpu_we` is low and address bit 31 is 0. A refill runs exactly four beats. `wb_cyc_o` and `wb_stb_o` stay high without a gap for the whole burst, and `wb_sel_o` is 4'b1111 on every beat, whatever `cpu_sel` holds.
- R3: A refill's first beat address is the request's bits [31:4], then word index `cpu_addr[3:2]`, then 2'b00. Each later beat adds one to the word index modulo 4. `wb_adr_o` holds its value while a beat has no ACK.
- R4: Changes on `cpu_addr` (bit 31 included), `cpu_sel` or `cpu_wdata` after acceptance have no effect on the running access. Its byte selects, beat addresses and beat count all stay as they were.
- R5: A read with address bit 31 set is a single access. It drives the full request address and `cpu_sel`, and its one response has `rsp_fill`=0 and `rsp_last`=1.
- R6: A write is a single access even when the address is cacheable. It drives `wb_we_o`=1, `cpu_wdata`, `cpu_sel` and the full address.
- R7: A read made while `cache_en` is low is a single access with `cpu_sel`, even when the address is cacheable.
- R8: While `wb_cyc_o` is low, `wb_sel_o` equals `cpu_sel`.
- R9: `wb_cyc_o` drops in the cycle after the final ACK. `rq_ready` is low whenever `wb_cyc_o` is high.
- R10: Every ACK produces one `rsp_valid` pulse in the next cycle. The pulse carries that beat's data, its word index and `rsp_fill`, and `rsp_last` is high only for the final beat.
- R11: ERR ends the access. `wb_cyc_o` drops the next cycle, and the response for that beat has `rsp_err`=1 and `rsp_last`=1. If ERR and ACK arrive in the same cycle, ERR wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cache_en | input | 1 | Data cache enabled |
| rq_valid | input | 1 | Request present |
| rq_ready | output | 1 | Block idle, request taken this cycle |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | 32 | Request byte address; bit 31 marks uncached |
| cpu_sel | input | 4 | Request byte selects |
| cpu_wdata | input | 32 | Write data |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_adr_o | output | 32 | Wishbone address |
| wb_sel_o | output | 4 | Wishbone byte selects |
| wb_dat_o | output | 32 | Wishbone write data |
| wb_dat_i | input | 32 | Wishbone read data |
| wb_ack_i | input | 1 | Wishbone acknowledge |
| wb_err_i | input | 1 | Wishbone error |
| rsp_valid | output | 1 | Response strobe, one per beat |
| rsp_data | output | 32 | Returned word |
| rsp_idx | output | 2 | Word index of the returned word in its line |
| rsp_fill | output | 1 | Word belongs to a line refill |
| rsp_last | output | 1 | Final response of the access |
| rsp_err | output | 1 | Access ended with a bus error |

## Verification
Two things can fall in the same cycle: a one-cycle flip of the inhibit bit and byte selects on the CPU side, and a beat acknowledgement. The bench produces this with a zero-wait slave, so every burst cycle carries an ACK, and then flips `cpu_addr[31]` and `cpu_sel` for exactly one cycle in the middle of a refill. The result is judged by the logged beat addresses, the selects and the number of beats. A second collision is ERR and ACK raised together. That run is judged by one response with the error flag set and by the cycle being dropped on the next clock.

// File: rtl/crb_pkg.sv
// Shared types for the cache refill burst master.
package crb_pkg;

    // Sequencer state: idle, running a line refill, or a single access.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_SINGLE = 2'd2
    } crb_state_e;

endpackage

// File: rtl/crb_qualify.sv
// Access qualifier.
// Decides from the request whether the access is a line refill, and which
// byte selects it drives. Both results are registered on the accept cycle
// and held until the next accept, so later input changes cannot reach them.
// Assumes the inhibit flag is one address bit, set meaning uncached.
module crb_qualify #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             cache_en,
    input  logic             we,
    input  logic             inhibit,
    input  logic [SEL_W-1:0] sel_in,
    output logic             fill_q,
    output logic [SEL_W-1:0] sel_q
);

    logic             fill_live;
    logic [SEL_W-1:0] sel_live;

    // Purpose: a refill needs an enabled cache, a read and a cacheable region.
    always_comb begin
        fill_live = cache_en && !we && !inhibit;
    end

    // Each byte lane is forced on for a refill, otherwise it follows the request.
    for (genvar lane = 0; lane < SEL_W; lane++) begin : g_lane
        assign sel_live[lane] = fill_live | sel_in[lane];
    end

    // Purpose: freeze the decision and the selects on the accept cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= 1'b0;
            sel_q  <= '0;
        end else if (capture) begin
            fill_q <= fill_live;
            sel_q  <= sel_live;
        end
    end

endmodule

// File: rtl/crb_beat_seq.sv
// Beat sequencer.
// Runs one access: either BEATS beats for a refill or one beat otherwise.
// A beat advances only on ACK. ERR ends the access at once. The word index
// starts at the requested word and wraps inside the line.
// Assumes BEATS is a power of two and at least two.
module crb_beat_seq
    import crb_pkg::*;
#(
    parameter int BEATS = 4,
    localparam int IDX_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             fill,
    input  logic [IDX_W-1:0] start_idx,
    input  logic             ack,
    input  logic             err,
    output logic             busy,
    output logic [IDX_W-1:0] beat_idx,
    output logic             last_beat
);

    localparam logic [IDX_W-1:0] LAST_CNT = IDX_W'(BEATS - 1);

    crb_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] cnt_q;

    // Purpose: decode busy and final-beat from the state and beat count.
    always_comb begin
        busy      = (state_q != ST_IDLE);
        last_beat = (state_q == ST_SINGLE) ||
                    ((state_q == ST_FILL) && (cnt_q == LAST_CNT));
        beat_idx  = idx_q;
    end

    // Purpose: step state, word index and beat count on bus responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= fill ? ST_FILL : ST_SINGLE;
                        idx_q   <= start_idx;
                        cnt_q   <= '0;
                    end
                end
                default: begin
                    if (err) begin
                        state_q <= ST_IDLE;
                    end else if (ack) begin
                        if (last_beat) begin
                            state_q <= ST_IDLE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/crb_resp.sv
// Response register.
// Turns each bus response that ends a beat into a one-cycle strobe toward
// the requester, one cycle after the ACK or ERR. ERR outranks ACK.
module crb_resp #(
    parameter int DW    = 32,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             ack,
    input  logic             err,
    input  logic             last_beat,
    input  logic             fill,
    input  logic [IDX_W-1:0] beat_idx,
    input  logic [DW-1:0]    dat_in,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_data,
    output logic [IDX_W-1:0] rsp_idx,
    output logic             rsp_fill,
    output logic             rsp_last,
    output logic             rsp_err
);

    logic beat_end;

    // Purpose: a beat ends on ACK or ERR, but only while an access runs.
    always_comb begin
        beat_end = busy && (ack || err);
    end

    // Purpose: register the returned word and its tags for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_idx   <= '0;
            rsp_fill  <= 1'b0;
            rsp_last  <= 1'b0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= beat_end;
            if (beat_end) begin
                rsp_data <= dat_in;
                rsp_idx  <= beat_idx;
                rsp_fill <= fill;
                rsp_last <= err || last_beat;
                rsp_err  <= err;
            end
        end
    end

endmodule

// File: rtl/crb_master.sv
// Cache refill burst master (top).
// Takes one request at a time from the cache. It runs a wrapping line-refill
// burst or a single Wishbone access, and returns one response per beat.
// Address, write data, the refill decision and the byte selects are all
// captured on the accept cycle, so the bus side stays steady for the whole
// access. Assumes the slave holds neither ACK nor ERR while CYC is low.
module crb_master #(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int BEATS  = 4,
    parameter int CI_BIT = AW - 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cache_en,
    input  logic                     rq_valid,
    output logic                     rq_ready,
    input  logic                     cpu_we,
    input  logic [AW-1:0]            cpu_addr,
    input  logic [DW/8-1:0]          cpu_sel,
    input  logic [DW-1:0]            cpu_wdata,
    output logic                     wb_cyc_o,
    output logic                     wb_stb_o,
    output logic                     wb_we_o,
    output logic [AW-1:0]            wb_adr_o,
    output logic [DW/8-1:0]          wb_sel_o,
    output logic [DW-1:0]            wb_dat_o,
    input  logic [DW-1:0]            wb_dat_i,
    input  logic                     wb_ack_i,
    input  logic                     wb_err_i,
    output logic                     rsp_valid,
    output logic [DW-1:0]            rsp_data,
    output logic [$clog2(BEATS)-1:0] rsp_idx,
    output logic                     rsp_fill,
    output logic                     rsp_last,
    output logic                     rsp_err
);

    localparam int SEL_W = DW / 8;
    localparam int OFFS  = $clog2(SEL_W);
    localparam int IDX_W = $clog2(BEATS);
    localparam int LINE  = OFFS + IDX_W;

    logic             start;
    logic             busy;
    logic             fill_q;
    logic [SEL_W-1:0] sel_q;
    logic [IDX_W-1:0] beat_idx;
    logic             last_beat;
    logic [AW-1:LINE] line_q;
    logic [OFFS-1:0]  byte_q;
    logic             we_q;
    logic [DW-1:0]    wdata_q;

    // Purpose: accept a request only while no access runs.
    always_comb begin
        rq_ready = !busy;
        start    = rq_valid && !busy;
    end

    // Purpose: hold the address, direction and write data of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q  <= '0;
            byte_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else if (start) begin
            line_q  <= cpu_addr[AW-1:LINE];
            byte_q  <= cpu_addr[OFFS-1:0];
            we_q    <= cpu_we;
            wdata_q <= cpu_wdata;
        end
    end

    crb_qualify #(
        .SEL_W (SEL_W)
    ) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (start),
        .cache_en (cache_en),
        .we       (cpu_we),
        .inhibit  (cpu_addr[CI_BIT]),
        .sel_in   (cpu_sel),
        .fill_q   (fill_q),
        .sel_q    (sel_q)
    );

    crb_beat_seq #(
        .BEATS (BEATS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .fill      (cache_en && !cpu_we && !cpu_addr[CI_BIT]),
        .start_idx (cpu_addr[LINE-1:OFFS]),
        .ack       (wb_ack_i),
        .err       (wb_err_i),
        .busy      (busy),
        .beat_idx  (beat_idx),
        .last_beat (last_beat)
    );

    crb_resp #(
        .DW    (DW),
        .IDX_W (IDX_W)
    ) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .ack       (wb_ack_i),
        .err       (wb_err_i),
        .last_beat (last_beat),
        .fill      (fill_q),
        .beat_idx  (beat_idx),
        .dat_in    (wb_dat_i),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_idx   (rsp_idx),
        .rsp_fill  (rsp_fill),
        .rsp_last  (rsp_last),
        .rsp_err   (rsp_err)
    );

    // Purpose: drive the bus from held state; selects pass through only when idle.
    always_comb begin
        wb_cyc_o = busy;
        wb_stb_o = busy;
        wb_we_o  = busy && we_q;
        wb_dat_o = wdata_q;
        wb_adr_o = {line_q, beat_idx, (fill_q ? {OFFS{1'b0}} : byte_q)};
        wb_sel_o = busy ? sel_q : cpu_sel;
    end

endmodule

// File: rtl/crb_master_chk.sv
// Property checker for crb_master, attached by bind.
// Keeps one flag of its own: whether the accepted access should be single.
module crb_master_chk #(
    parameter int AW    = 32,
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rq_valid,
    input logic             rq_ready,
    input logic             cpu_we,
    input logic             ci_bit,
    input logic             cache_en,
    input logic             wb_cyc_o,
    input logic             wb_stb_o,
    input logic [AW-1:0]    wb_adr_o,
    input logic [SEL_W-1:0] wb_sel_o,
    input logic             wb_ack_i,
    input logic             wb_err_i,
    input logic             rsp_valid,
    input logic             rsp_fill,
    input logic             rsp_last,
    input logic             rsp_err
);

    logic single_q;

    // Purpose: note at acceptance whether the access must be a single beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            single_q <= 1'b0;
        end else if (rq_valid && rq_ready) begin
            single_q <= cpu_we || ci_bit || !cache_en;
        end
    end

    AST_STB_WITH_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb_o == wb_cyc_o); // R2
    AST_FILL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fill) |-> ($past(wb_sel_o) == {SEL_W{1'b1}})); // R2
    AST_ADR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && !wb_ack_i && !wb_err_i) |=> $stable(wb_adr_o)); // R3
    AST_SEL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && $past(wb_cyc_o)) |-> $stable(wb_sel_o)); // R4
    AST_SINGLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && single_q) |-> (rsp_last && !rsp_fill)); // R5
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc_o |-> !rq_ready); // R9
    AST_BEAT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && (wb_ack_i || wb_err_i)) |=> rsp_valid); // R10
    AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && wb_err_i) |=> (!wb_cyc_o && rsp_err && rsp_last)); // R11

endmodule

bind crb_master crb_master_chk #(
    .AW    (AW),
    .SEL_W (DW / 8)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rq_valid  (rq_valid),
    .rq_ready  (rq_ready),
    .cpu_we    (cpu_we),
    .ci_bit    (cpu_addr[CI_BIT]),
    .cache_en  (cache_en),
    .wb_cyc_o  (wb_cyc_o),
    .wb_stb_o  (wb_stb_o),
    .wb_adr_o  (wb_adr_o),
    .wb_sel_o  (wb_sel_o),
    .wb_ack_i  (wb_ack_i),
    .wb_err_i  (wb_err_i),
    .rsp_valid (rsp_valid),
    .rsp_fill  (rsp_fill),
    .rsp_last  (rsp_last),
    .rsp_err   (rsp_err)
);

// File: tb/crb_master_test.sv
// Directed bench for crb_master: one task per scenario plus a Wishbone slave model.
module crb_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b1;
    logic        rq_valid = 1'b0;
    logic        rq_ready;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [3:0]  cpu_sel = '0;
    logic [31:0] cpu_wdata = '0;
    logic        wb_cyc_o, wb_stb_o, wb_we_o;
    logic [31:0] wb_adr_o, wb_dat_o, wb_dat_i;
    logic [3:0]  wb_sel_o;
    logic        ack = 1'b0, err = 1'b0;
    logic        rsp_valid, rsp_fill, rsp_last, rsp_err;
    logic [31:0] rsp_data;
    logic [1:0]  rsp_idx;

    always #10 clk = ~clk;

    crb_master uut (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
        .rq_valid(rq_valid), .rq_ready(rq_ready), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
        .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
        .wb_adr_o(wb_adr_o), .wb_sel_o(wb_sel_o), .wb_dat_o(wb_dat_o),
        .wb_dat_i(wb_dat_i), .wb_ack_i(ack), .wb_err_i(err),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_idx(rsp_idx),
        .rsp_fill(rsp_fill), .rsp_last(rsp_last), .rsp_err(rsp_err)
    );

    function automatic logic [31:0] fmem(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
    endfunction

    always_comb wb_dat_i = fmem(wb_adr_o);

    int n_chk = 0, n_bad = 0;
    int wait_n = 0, err_at = -1;
    bit err_ack = 1'b0;
    int sl_cnt = 0;
    int n_beat = 0, n_rsp = 0, n_drop = 0, n_cont = 0;
    logic [31:0] lg_adr[16];
    logic [3:0]  lg_sel[16];
    logic        lg_we[16];
    logic [31:0] lg_wd[16];
    logic [31:0] r_dat[16];
    logic [1:0]  r_idx[16];
    logic        r_fill[16], r_last[16], r_err[16];

    // Slave model and monitor, all on the falling edge.
    always @(negedge clk) begin
        if (ack || err) begin
            if (wb_cyc_o) n_cont++; else n_drop++;
        end
        ack = 1'b0;
        err = 1'b0;
        if (rsp_valid && n_rsp < 16) begin
            r_dat[n_rsp] = rsp_data;  r_idx[n_rsp] = rsp_idx;
            r_fill[n_rsp] = rsp_fill; r_last[n_rsp] = rsp_last;
            r_err[n_rsp] = rsp_err;   n_rsp++;
        end
        if (wb_cyc_o && wb_stb_o) begin
            if (sl_cnt >= wait_n) begin
                if (n_beat < 16) begin
                    lg_adr[n_beat] = wb_adr_o; lg_sel[n_beat] = wb_sel_o;
                    lg_we[n_beat] = wb_we_o;   lg_wd[n_beat] = wb_dat_o;
                end
                if (n_beat == err_at) begin err = 1'b1; ack = err_ack; end
                else ack = 1'b1;
                n_beat++;
                sl_cnt = 0;
            end else sl_cnt++;
        end else sl_cnt = 0;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One request; optional one-cycle glitch of address msb, selects and data.
    task automatic run_tx(input bit en, input bit we, input logic [31:0] a,
                          input logic [3:0] s, input logic [31:0] wd, input int glitch_at);
        n_beat = 0; n_rsp = 0; n_drop = 0; n_cont = 0;
        @(negedge clk); #1;
        cache_en = en; cpu_we = we; cpu_addr = a; cpu_sel = s; cpu_wdata = wd;
        rq_valid = 1'b1;
        @(negedge clk); #1;
        rq_valid = 1'b0;
        for (int c = 0; c < 80; c++) begin
            if (glitch_at >= 0 && c == glitch_at) begin
                cpu_addr[31] = ~a[31]; cpu_sel = ~s; cpu_wdata = ~wd;
            end
            if (glitch_at >= 0 && c == glitch_at + 1) begin
                cpu_addr = a; cpu_sel = s; cpu_wdata = wd;
            end
            if (n_drop > 0) break;
            @(negedge clk); #1;
        end
        cpu_addr = a; cpu_sel = s; cpu_wdata = wd;
        chk("R9", "cycle ended once after final response", n_drop, 1);
        chk("R9", "cyc low after final ack", {31'b0, wb_cyc_o}, 0);
        chk("R9", "ready after final ack", {31'b0, rq_ready}, 1);
    endtask

    task automatic check_fill(input logic [31:0] a, input string tag);
        chk("R2", {tag, " beat count"}, n_beat, 4);
        chk("R10", {tag, " response count"}, n_rsp, 4);
        for (int k = 0; k < 4; k++) begin
            logic [1:0]  ix;
            logic [31:0] ea;
            ix = a[3:2] + 2'(k);
            ea = {a[31:4], ix, 2'b00};
            chk("R3", {tag, " beat address"}, lg_adr[k], ea);
            chk("R2", {tag, " beat selects all lanes"}, {28'b0, lg_sel[k]}, 32'hF);
            chk("R2", {tag, " read beat"}, {31'b0, lg_we[k]}, 0);
            chk("R10", {tag, " data"}, r_dat[k], fmem(ea));
            chk("R10", {tag, " index"}, {30'b0, r_idx[k]}, {30'b0, ix});
            chk("R10", {tag, " fill flag"}, {31'b0, r_fill[k]}, 1);
            chk("R10", {tag, " last flag"}, {31'b0, r_last[k]}, (k == 3) ? 1 : 0);
        end
    endtask

    task automatic check_single(input string req, input logic [31:0] a,
                                input logic [3:0] s, input bit we, input logic [31:0] wd);
        chk(req, "beat count", n_beat, 1);
        chk(req, "address", lg_adr[0], a);
        chk(req, "selects from request", {28'b0, lg_sel[0]}, {28'b0, s});
        chk(req, "write enable", {31'b0, lg_we[0]}, {31'b0, we});
        if (we) chk(req, "write data", lg_wd[0], wd);
        else    chk(req, "read data", r_dat[0], fmem(a));
        chk(req, "response count", n_rsp, 1);
        chk(req, "no fill flag", {31'b0, r_fill[0]}, 0);
        chk(req, "last flag", {31'b0, r_last[0]}, 1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "cyc in reset", {31'b0, wb_cyc_o}, 0);
        chk("R1", "ready in reset", {31'b0, rq_ready}, 1);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1", "cyc after reset", {31'b0, wb_cyc_o}, 0);
        chk("R1", "stb after reset", {31'b0, wb_stb_o}, 0);
        chk("R1", "rsp after reset", {31'b0, rsp_valid}, 0);
        chk("R1", "ready after reset", {31'b0, rq_ready}, 1);
    endtask

    task automatic t_fill_basic();
        wait_n = 0; err_at = -1;
        run_tx(1'b1, 1'b0, 32'h0000_1238, 4'b0010, 32'h0, -1);
        check_fill(32'h0000_1238, "R2 zero-wait refill");
        chk("R2", "cyc held between beats", n_cont, 3);
    endtask

    task automatic t_fill_wait();
        wait_n = 2; err_at = -1;
        run_tx(1'b1, 1'b0, 32'h0000_5A04, 4'b1000, 32'h0, -1);
        check_fill(32'h0000_5A04, "R3 stalled refill");
        wait_n = 0;
    endtask

    task automatic t_glitch(input int w, input int at, input logic [31:0] a);
        wait_n = w; err_at = -1;
        run_tx(1'b1, 1'b0, a, 4'b0100, 32'h0, at);
        check_fill(a, "R4 glitch during refill");
        wait_n = 0;
    endtask

    task automatic t_uncached();
        run_tx(1'b1, 1'b0, 32'h8000_0106, 4'b1100, 32'h0, -1);
        check_single("R5", 32'h8000_0106, 4'b1100, 1'b0, 32'h0);
    endtask

    task automatic t_write();
        run_tx(1'b1, 1'b1, 32'h0000_0300, 4'b0011, 32'hCAFE_F00D, -1);
        check_single("R6", 32'h0000_0300, 4'b0011, 1'b1, 32'hCAFE_F00D);
    endtask

    task automatic t_disabled();
        run_tx(1'b0, 1'b0, 32'h0000_0414, 4'b0001, 32'h0, -1);
        check_single("R7", 32'h0000_0414, 4'b0001, 1'b0, 32'h0);
        cache_en = 1'b1;
    endtask

    task automatic t_idle_sel();
        @(negedge clk); #1;
        cpu_sel = 4'b0101; #1;
        chk("R8", "idle select passthrough", {28'b0, wb_sel_o}, 32'h5);
        cpu_sel = 4'b1010; #1;
        chk("R8", "idle select passthrough", {28'b0, wb_sel_o}, 32'hA);
    endtask

    task automatic t_err_mid();
        wait_n = 0; err_at = 1; err_ack = 1'b0;
        run_tx(1'b1, 1'b0, 32'h0000_0040, 4'b0001, 32'h0, -1);
        chk("R11", "beats before abort", n_beat, 2);
        chk("R11", "responses", n_rsp, 2);
        chk("R11", "first beat clean", {31'b0, r_err[0]}, 0);
        chk("R11", "error flag", {31'b0, r_err[1]}, 1);
        chk("R11", "error is last", {31'b0, r_last[1]}, 1);
        err_at = -1;
    endtask

    task automatic t_err_with_ack();
        wait_n = 0; err_at = 0; err_ack = 1'b1;
        run_tx(1'b1, 1'b0, 32'h0000_0080, 4'b0001, 32'h0, -1);
        chk("R11", "err beats ack: beats", n_beat, 1);
        chk("R11", "err beats ack: responses", n_rsp, 1);
        chk("R11", "err beats ack: flag", {31'b0, r_err[0]}, 1);
        err_at = -1; err_ack = 1'b0;
    endtask

    initial begin
        t_reset();
        t_fill_basic();
        t_fill_wait();
        t_glitch(0, 1, 32'h0000_0F0C);
        t_glitch(1, 2, 32'h0000_7000);
        t_uncached();
        t_write();
        t_disabled();
        t_idle_sel();
        t_err_mid();
        t_err_with_ack();
        t_fill_basic();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule